// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Controller

This block is the digital front end of a two-channel current-output converter. A three-wire serial port carries an address-plus-data word. The port has a select line, a data line and a serial clock. When the select line rises, the word is decoded and its data is written into the input register of channel A, of channel B, of both channels or of neither. Each channel has a second register, the output register, and that register drives the converter code. An active-low load strobe moves both input registers into the output registers at the same time. If the strobe is held low permanently, each frame reaches the output directly.

All serial pins are sampled by the system clock `clk`, and both serial-clock and select edges are found by comparing each sample with the previous one. The block keeps exactly one word of history. Only the most recent bits decide a frame, so a longer transfer built from whole bytes still works. A functional preset input and the power-on reset both load all four channel registers with a code chosen by a static select input: zero scale when it is 0, midscale when it is 1. A parameter picks 16 data bits (18-bit word) or 14 data bits (16-bit word). A one-cycle flag reports a frame that ended before a full word had been clocked in.

Top module: `dac2_ctrl`

## Requirements
- R1: A word is WORD_W = DATA_W+2 bits, sent MSB first. The two leading bits are the address: bit WORD_W-1 first, then bit WORD_W-2. The DATA_W data bits follow, most significant first.
- R2: A bit enters the shift register on a sampled rising edge of `sclk` only while `cs_n` is low. Serial-clock edges while `cs_n` is high leave the shift register unchanged.
- R3: On a sampled rising edge of `cs_n`, only the last WORD_W bits shifted in are decoded. For example, with 16 data bits, the top 6 bits of a 24-bit transfer are discarded.
- R4: Address decode: 2'b00 writes no channel, 2'b01 writes channel A, 2'b10 writes channel B, and 2'b11 writes the same data into both channels. The input register is written on the clock edge that samples `cs_n` rising.
- R5: While `load_n` is sampled low, each output register takes the value its input register held at that edge. While `load_n` is high, both outputs hold.
- R6: With `load_n` held low, an addressed output shows the new code one cycle after its input register is written (single-buffered mode).
- R7: A sampled low `preset_n` sets both input and both output registers to 0 when `mid_sel` is 0, and to 1<<(DATA_W-1) when `mid_sel` is 1. Preset wins over a frame load and over `load_n`. It leaves the shift register untouched.
- R8: `rst` (synchronous, active high, power-on) applies the same zero-or-midscale preset by `mid_sel`, and clears the shift register and bit counter.
- R9: `short_frame` pulses high for one cycle, one cycle after a `cs_n` rising edge is sampled, if fewer than WORD_W bits were shifted since `cs_n` fell. That frame still loads whatever the shift register holds.
- R10: With DATA_W = 14 the word is 16 bits and the midscale code is 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Output-register load strobe, active low, level sensitive |
| preset_n | input | 1 | Functional preset, active low |
| mid_sel | input | 1 | Preset code select: 0 zero scale, 1 midscale |
| code_a | output | DATA_W | Channel A converter code |
| code_b | output | DATA_W | Channel B converter code |
| short_frame | output | 1 | One-cycle flag for a frame with fewer than WORD_W bits |

## Verification
The input register is written on the clock edge that samples `cs_n` high after a low sample. An output register follows one edge after its input register when `load_n` is low. So a frame reaches `code_a`/`code_b` two edges after the select rise is sampled. A preset reaches the outputs on the very next edge. `short_frame` is registered and appears one edge after the select rise. The bench drives pins on falling edges. Its reference model advances at each rising edge with exactly these latencies, and every output is compared at the next falling edge. Directed checks are taken only after several idle cycles have followed each frame or strobe.

// File: rtl/dac2_pkg.sv
package dac2_pkg;

    localparam int NUM_CH = 2;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        DEST_NONE = 2'b00,
        DEST_A    = 2'b01,
        DEST_B    = 2'b10,
        DEST_BOTH = 2'b11
    } dest_e;

    // Channel write mask, bit 0 = channel A, bit 1 = channel B.
    function automatic logic [NUM_CH-1:0] dest_to_mask(dest_e d);
        logic [NUM_CH-1:0] m;
        case (d)
            DEST_A:    m = 2'b01;
            DEST_B:    m = 2'b10;
            DEST_BOTH: m = 2'b11;
            default:   m = 2'b00;
        endcase
        return m;
    endfunction

    // Zero-scale or midscale code for a given data width.
    function automatic logic [31:0] preset_code(int unsigned dw, logic mid);
        return mid ? (32'd1 << (dw - 1)) : 32'd0;
    endfunction

endpackage

// File: rtl/dac2_serial_rx.sv
module dac2_serial_rx
    import dac2_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int WORD_W = DATA_W + ADDR_W,
    localparam int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic [WORD_W-1:0] word,
    output logic              frame_done,
    output logic              frame_short
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    logic              sclk_q;
    logic              cs_q;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              shift_en;

    assign shift_en   = sclk & ~sclk_q & ~cs_n;
    assign frame_done = cs_n & ~cs_q;
    assign word       = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q      <= 1'b0;
            cs_q        <= 1'b1;
            shreg       <= '0;
            bit_cnt     <= '0;
            frame_short <= 1'b0;
        end else begin
            sclk_q      <= sclk;
            cs_q        <= cs_n;
            frame_short <= frame_done && (bit_cnt < FULL_CNT);
            if (shift_en) begin
                shreg <= {shreg[WORD_W-2:0], sdi};
            end
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (shift_en && (bit_cnt != FULL_CNT)) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dac2_word_decode.sv
module dac2_word_decode
    import dac2_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int WORD_W = DATA_W + ADDR_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              frame_done,
    output logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] wr_en
);

    dest_e dest;

    always_comb begin
        dest    = dest_e'(word[WORD_W-1 -: ADDR_W]);
        wr_data = word[DATA_W-1:0];
        wr_en   = frame_done ? dest_to_mask(dest) : '0;
    end

endmodule

// File: rtl/dac2_chan_regs.sv
module dac2_chan_regs
    import dac2_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              preset_n,
    input  logic              mid_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_n,
    output logic [DATA_W-1:0] in_code,
    output logic [DATA_W-1:0] out_code
);

    logic [DATA_W-1:0] preset_val;

    assign preset_val = DATA_W'(preset_code(DATA_W, mid_sel));

    always_ff @(posedge clk) begin
        if (rst || !preset_n) begin
            in_code  <= preset_val;
            out_code <= preset_val;
        end else begin
            if (wr_en) begin
                in_code <= wr_data;
            end
            if (!load_n) begin
                out_code <= in_code;
            end
        end
    end

endmodule

// File: rtl/dac2_ctrl.sv
module dac2_ctrl
    import dac2_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              load_n,
    input  logic              preset_n,
    input  logic              mid_sel,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              short_frame
);

    localparam int WORD_W = DATA_W + ADDR_W;

    logic [WORD_W-1:0] rx_word;
    logic              rx_done;
    logic [DATA_W-1:0] wr_data;
    logic [NUM_CH-1:0] wr_en;
    logic [DATA_W-1:0] in_code  [NUM_CH];
    logic [DATA_W-1:0] out_code [NUM_CH];

    dac2_serial_rx #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .sdi         (sdi),
        .word        (rx_word),
        .frame_done  (rx_done),
        .frame_short (short_frame)
    );

    dac2_word_decode #(.DATA_W(DATA_W)) u_dec (
        .word       (rx_word),
        .frame_done (rx_done),
        .wr_data    (wr_data),
        .wr_en      (wr_en)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dac2_chan_regs #(.DATA_W(DATA_W)) u_regs (
            .clk      (clk),
            .rst      (rst),
            .preset_n (preset_n),
            .mid_sel  (mid_sel),
            .wr_en    (wr_en[ch]),
            .wr_data  (wr_data),
            .load_n   (load_n),
            .in_code  (in_code[ch]),
            .out_code (out_code[ch])
        );
    end

    assign code_a = out_code[0];
    assign code_b = out_code[1];

endmodule

// File: rtl/dac2_ctrl_chk.sv
module dac2_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int WORD_W = DATA_W + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              load_n,
    input logic              preset_n,
    input logic              mid_sel,
    input logic [DATA_W-1:0] code_a,
    input logic [DATA_W-1:0] code_b,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic [WORD_W-1:0] shreg,
    input logic              short_frame
);

    localparam logic [DATA_W-1:0] MID  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ZERO = '0;

    // R7: preset drives both outputs to the selected code
    assert_preset_code_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(preset_n) |->
            (code_a == ($past(mid_sel) ? MID : ZERO)) &&
            (code_b == ($past(mid_sel) ? MID : ZERO)));

    // R5: outputs hold while the strobe is high
    assert_strobe_hold_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(load_n) && $past(preset_n) && !$past(rst)) |->
            ($stable(code_a) && $stable(code_b)));

    // R5: outputs take the input registers while the strobe is low
    assert_strobe_follow_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(load_n) && $past(preset_n) && !$past(rst)) |->
            (code_a == $past(in_a)) && (code_b == $past(in_b)));

    // R2: no shifting while the frame select is high
    assert_idle_no_shift_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) && !$past(rst)) |-> $stable(shreg));

    // R9: the short flag only follows a select rising edge
    assert_short_after_rise_R9: assert property (@(posedge clk) disable iff (rst)
        short_frame |-> ($past(cs_n) && !$past(cs_n, 2)));

endmodule

bind dac2_ctrl dac2_ctrl_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .load_n      (load_n),
    .preset_n    (preset_n),
    .mid_sel     (mid_sel),
    .code_a      (code_a),
    .code_b      (code_b),
    .in_a        (in_code[0]),
    .in_b        (in_code[1]),
    .shreg       (rx_word),
    .short_frame (short_frame)
);

// File: tb/dac2_ctrl_tb.sv
`timescale 1ns/1ps
module dac2_ctrl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic load_n = 1'b1;
    logic preset_n = 1'b1;
    logic mid_sel = 1'b0;

    logic [15:0] a16, b16;
    logic [13:0] a14, b14;
    logic        sh16, sh14;

    always #2.5 clk = ~clk;

    dac2_ctrl #(.DATA_W(16)) u_dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .load_n(load_n), .preset_n(preset_n), .mid_sel(mid_sel),
        .code_a(a16), .code_b(b16), .short_frame(sh16)
    );

    dac2_ctrl #(.DATA_W(14)) u_dut14 (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .load_n(load_n), .preset_n(preset_n), .mid_sel(mid_sel),
        .code_a(a14), .code_b(b14), .short_frame(sh14)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R8";

    // ---------------- behavioural reference model ----------------
    localparam int WW [2] = '{16, 14};
    int exp_in  [2][2];
    int exp_out [2][2];
    bit exp_short [2];
    bit hist [$];
    int cnt;
    bit p_sclk, p_cs;
    bit model_ok = 0;
    bit seen_short = 0;

    always @(posedge clk) begin
        automatic bit rs = sclk && !p_sclk;
        automatic bit cr = cs_n && !p_cs;
        if (rst) begin
            for (int v = 0; v < 2; v++) begin
                for (int c = 0; c < 2; c++) begin
                    exp_in[v][c]  = mid_sel ? (1 << (WW[v] - 1)) : 0;
                    exp_out[v][c] = exp_in[v][c];
                end
                exp_short[v] = 0;
            end
            hist.delete();
            cnt = 0;
            p_sclk = 0;
            p_cs = 1;
            model_ok = 1;
        end else begin
            for (int v = 0; v < 2; v++) begin
                automatic int w = WW[v];
                automatic int word = 0;
                automatic int addr;
                automatic int data;
                exp_short[v] = cr && (cnt < w + 2);
                for (int i = 0; i < w + 2; i++)
                    if (hist.size() > i) word |= int'(hist[hist.size() - 1 - i]) << i;
                addr = word >> w;
                data = word & ((1 << w) - 1);
                if (!preset_n) begin
                    for (int c = 0; c < 2; c++) begin
                        exp_in[v][c]  = mid_sel ? (1 << (w - 1)) : 0;
                        exp_out[v][c] = exp_in[v][c];
                    end
                end else begin
                    if (!load_n)
                        for (int c = 0; c < 2; c++) exp_out[v][c] = exp_in[v][c];
                    if (cr) begin
                        if (addr & 1) exp_in[v][0] = data;
                        if (addr & 2) exp_in[v][1] = data;
                    end
                end
            end
            if (cs_n) cnt = 0;
            else if (rs) begin
                hist.push_back(sdi);
                if (hist.size() > 64) void'(hist.pop_front());
                if (cnt < 64) cnt++;
            end
            p_sclk = sclk;
            p_cs = cs_n;
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_ok && !done) begin
            cmp("code_a 16b", int'(a16), exp_out[0][0]);
            cmp("code_b 16b", int'(b16), exp_out[0][1]);
            cmp("code_a 14b", int'(a14), exp_out[1][0]);
            cmp("code_b 14b", int'(b14), exp_out[1][1]);
            cmp("short 16b", int'(sh16), int'(exp_short[0]));
            cmp("short 14b", int'(sh14), int'(exp_short[1]));
            if (sh16) seen_short = 1;
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(logic [31:0] bits, int n);
        @(negedge clk); cs_n = 1'b0;
        idle(2);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i]; sclk = 1'b0;
            idle(2);
            sclk = 1'b1;
            idle(2);
        end
        sclk = 1'b0;
        idle(2);
        cs_n = 1'b1;
        idle(5);
    endtask

    task automatic do_reset(bit mid);
        @(negedge clk); rst = 1'b1; mid_sel = mid;
        idle(3);
        rst = 1'b0;
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: power-on preset, zero then midscale
        cur_req = "R8";
        do_reset(1'b0);
        chk("R8", "code_a zero", int'(a16), 0);
        chk("R8", "code_b zero", int'(b16), 0);
        do_reset(1'b1);
        chk("R8", "code_a mid", int'(a16), 32'h8000);
        chk("R10", "code_b mid 14b", int'(b14), 32'h2000);
        mid_sel = 1'b0;

        // R6 / R1: single buffered, channel A
        cur_req = "R6";
        load_n = 1'b0;
        send_frame({14'd0, 2'b01, 16'h1234}, 18);
        chk("R1", "code_a after frame", int'(a16), 32'h1234);
        chk("R6", "code_b untouched", int'(b16), 32'h8000);

        // R4: address decode
        cur_req = "R4";
        send_frame({14'd0, 2'b10, 16'h5A5A}, 18);
        chk("R4", "B only: code_b", int'(b16), 32'h5A5A);
        chk("R4", "B only: code_a", int'(a16), 32'h1234);
        send_frame({14'd0, 2'b11, 16'h0F0F}, 18);
        chk("R4", "both: code_a", int'(a16), 32'h0F0F);
        chk("R4", "both: code_b", int'(b16), 32'h0F0F);
        send_frame({14'd0, 2'b00, 16'hFFFF}, 18);
        chk("R4", "none: code_a", int'(a16), 32'h0F0F);
        chk("R4", "none: code_b", int'(b16), 32'h0F0F);

        // R3: 24-bit transfer, top 6 bits dropped
        cur_req = "R3";
        send_frame({8'd0, 6'b101011, 2'b01, 16'hBEEF}, 24);
        chk("R3", "24-bit: code_a", int'(a16), 32'hBEEF);
        chk("R3", "24-bit: 14b code_b", int'(b14), 32'h3EEF);

        // R5: double buffered simultaneous update
        cur_req = "R5";
        load_n = 1'b1;
        send_frame({14'd0, 2'b01, 16'h1111}, 18);
        send_frame({14'd0, 2'b10, 16'h2222}, 18);
        chk("R5", "held code_a", int'(a16), 32'hBEEF);
        chk("R5", "held code_b", int'(b16), 32'h0F0F);
        @(negedge clk); load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
        idle(2);
        chk("R5", "strobed code_a", int'(a16), 32'h1111);
        chk("R5", "strobed code_b", int'(b16), 32'h2222);

        // R2 / R9: idle clocks ignored, short frame still loads
        cur_req = "R2";
        load_n = 1'b0;
        send_frame({14'd0, 2'b00, 16'h4ABC}, 18);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); sdi = 1'b1; sclk = 1'b1;
            @(negedge clk); sclk = 1'b0;
        end
        cur_req = "R9";
        seen_short = 0;
        send_frame(32'b11, 2);
        chk("R2", "idle clocks ignored: code_a", int'(a16), 32'h2AF3);
        chk("R9", "short flag seen", int'(seen_short), 1);
        seen_short = 0;
        send_frame({14'd0, 2'b01, 16'h0001}, 18);
        chk("R9", "full frame not short", int'(seen_short), 0);

        // R7: functional preset
        cur_req = "R7";
        load_n = 1'b1;
        @(negedge clk); mid_sel = 1'b1; preset_n = 1'b0;
        @(negedge clk); preset_n = 1'b1;
        idle(1);
        chk("R7", "mid preset code_a", int'(a16), 32'h8000);
        chk("R7", "mid preset 14b code_a", int'(a14), 32'h2000);
        @(negedge clk); mid_sel = 1'b0; preset_n = 1'b0;
        @(negedge clk); preset_n = 1'b1;
        idle(1);
        chk("R7", "zero preset code_b", int'(b16), 0);

        // R10: 16-bit word for the 14-bit variant
        cur_req = "R10";
        load_n = 1'b0;
        send_frame({16'd0, 2'b11, 14'h1555}, 16);
        chk("R10", "14b code_a", int'(a14), 32'h1555);
        chk("R10", "14b code_b", int'(b14), 32'h1555);

        idle(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule